// File: doc/BRIEF.md
# Two-Level Lookup-Table Logic Cell

This block is a configurable logic cell built from truth-table memories. Two four-input tables, here called the F and G tables, each read a table bit addressed by their own four input pins. A smaller merge table with three address bits takes the F result, the G result and one extra pin. From these it builds functions of up to nine inputs inside a single cell. Each of the three table results leaves the block combinationally.

Two flip-flops sit beside the tables. Each one captures a source picked by configuration: the F result, the G result, the merge result, or a direct data pin. All flip-flops share a clock enable and a synchronous set/reset pin. For each flip-flop, configuration decides whether that pin forces it to 1 or to 0.

All table contents and flip-flop options come from one serial configuration image, shifted in a bit at a time. Until a complete image has arrived, every data output is held at 0.

Top module: `lut_clb`

## Requirements
- R1: The configuration image is 46 bits, shifted in MSB first, one bit on each clock edge where `cfg_en` is high. Image bits [15:0] are the F table, [31:16] the G table and [39:32] the merge table. Bits [41:40] are flip-flop 1's source and bit [42] its set/reset value. Bits [44:43] are flip-flop 2's source and bit [45] its set/reset value. `loaded` rises on the clock edge that takes the 46th bit.
- R2: While `loaded` is low, `f_out`, `g_out` and `h_out` are 0. At each clock edge where `loaded` is low, both flip-flops are cleared to 0. Starting a new image drops `loaded` at the first shift edge.
- R3: `f_out` equals F table bit number `f_in` (the input read as an unsigned index). `g_out` likewise equals G table bit number `g_in`.
- R4: `h_out` equals merge table bit number {`h_in`, G result, F result}, where `h_in` is the index MSB and the F result is the LSB.
- R5: With `loaded` high, `sr_in` low and `ce_in` high, each flip-flop takes its selected source at the clock edge. Source code 0 is the F result, 1 is the G result, 2 is the merge result and 3 is `d_in`.
- R6: With `loaded` high and `sr_in` high, each flip-flop takes its configured set/reset value at the clock edge, whatever `ce_in` is.
- R7: With `loaded` high, `sr_in` low and `ce_in` low, both flip-flops keep their value.
- R8: Asserting `rst_n` low clears `loaded` and both flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Shift one configuration bit this cycle |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| loaded | output | 1 | A complete image is in place |
| f_in | input | 4 | F table address |
| g_in | input | 4 | G table address |
| h_in | input | 1 | Extra merge table address bit (MSB) |
| d_in | input | 1 | Direct flip-flop data |
| ce_in | input | 1 | Flip-flop clock enable |
| sr_in | input | 1 | Synchronous set/reset, priority over enable |
| f_out | output | 1 | F table result |
| g_out | output | 1 | G table result |
| h_out | output | 1 | Merge table result |
| q1_out | output | 1 | Flip-flop 1 |
| q2_out | output | 1 | Flip-flop 2 |

## Verification
The three table outputs are combinational, so the bench drives addresses just after a falling edge and reads the results 1 ns later, within the same cycle. Flip-flop results and `loaded` each pass through one register. They are therefore checked at the falling edge that follows the capturing rising edge, and never before. The hold check changes inputs with the enable low and looks one edge later. The reload check inspects the outputs after ten shifts of a new image.

// File: rtl/clb_pkg.sv
package clb_pkg;

   typedef enum logic [1:0] {
      SRC_F      = 2'd0,
      SRC_G      = 2'd1,
      SRC_H      = 2'd2,
      SRC_DIRECT = 2'd3
   } ff_src_e;

   typedef struct packed {
      logic    srval;
      ff_src_e src;
   } ff_cfg_t;

   localparam int FF_CFG_W = $bits(ff_cfg_t);

endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
   parameter int LEN = 46
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shift_i,
   input  logic           bit_i,
   output logic [LEN-1:0] image_o,
   output logic           loaded_o
);
   localparam int CW = $clog2(LEN + 1);

   if (LEN < 2) begin : g_len_chk
      $error("clb_cfg_chain: LEN must be at least 2");
   end

   logic [LEN-1:0] shreg_q;
   logic [CW-1:0]  cnt_q;
   logic           loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         cnt_q    <= '0;
         loaded_q <= 1'b0;
      end else if (shift_i) begin
         shreg_q <= {shreg_q[LEN-2:0], bit_i};
         if (cnt_q == CW'(LEN - 1)) begin
            cnt_q    <= '0;
            loaded_q <= 1'b1;
         end else begin
            cnt_q    <= cnt_q + 1'b1;
            loaded_q <= 1'b0;
         end
      end
   end

   assign image_o  = shreg_q;
   assign loaded_o = loaded_q;

   // R1: the loaded flag only ever rises on a shift edge
   p_load_on_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loaded_q) |-> $past(shift_i));

   // R1: the image does not move without a shift
   p_image_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(shreg_q));

   // R1: the bit counter stays inside one image length
   p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(LEN));

endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
   parameter int K        = 4,
   parameter bit MUX_TREE = 1'b1
) (
   input  logic [(1<<K)-1:0] table_i,
   input  logic [K-1:0]      addr_i,
   output logic              out_o
);
   localparam int TAB = 1 << K;

   if (K < 1 || K > 8) begin : g_k_chk
      $error("clb_lut: K out of range");
   end

   if (MUX_TREE) begin : g_tree
      // heap-numbered nodes: root 1, leaves TAB..2*TAB-1
      logic [2*TAB-1:1] node;
      for (genvar j = 0; j < TAB; j++) begin : g_leaf
         assign node[TAB + j] = table_i[j];
      end
      for (genvar i = 1; i < TAB; i++) begin : g_node
         localparam int DEPTH = $clog2(i + 1) - 1;
         assign node[i] = addr_i[K-1-DEPTH] ? node[2*i+1] : node[2*i];
      end
      assign out_o = node[1];
   end else begin : g_index
      assign out_o = table_i[addr_i];
   end

endmodule

// File: rtl/clb_ff.sv
module clb_ff
   import clb_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    loaded_i,
   input  ff_src_e src_i,
   input  logic    srval_i,
   input  logic    f_i,
   input  logic    g_i,
   input  logic    h_i,
   input  logic    d_i,
   input  logic    ce_i,
   input  logic    sr_i,
   output logic    q_o
);
   logic d_sel;
   logic q_q;

   always_comb begin
      unique case (src_i)
         SRC_F:   d_sel = f_i;
         SRC_G:   d_sel = g_i;
         SRC_H:   d_sel = h_i;
         default: d_sel = d_i;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q_q <= 1'b0;
      else if (!loaded_i) q_q <= 1'b0;
      else if (sr_i)      q_q <= srval_i;
      else if (ce_i)      q_q <= d_sel;
   end

   assign q_o = q_q;

   p_clear_unloaded_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded_i |=> (q_q == 1'b0));

   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded_i && !sr_i && ce_i) |=> (q_q == $past(d_sel)));

   p_sr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded_i && sr_i) |=> (q_q == $past(srval_i)));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded_i && !sr_i && !ce_i) |=> $stable(q_q));

endmodule

// File: rtl/lut_clb.sv
module lut_clb
   import clb_pkg::*;
#(
   parameter int LUT_K    = 4,
   parameter bit MUX_TREE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_bit,
   output logic             loaded,
   input  logic [LUT_K-1:0] f_in,
   input  logic [LUT_K-1:0] g_in,
   input  logic             h_in,
   input  logic             d_in,
   input  logic             ce_in,
   input  logic             sr_in,
   output logic             f_out,
   output logic             g_out,
   output logic             h_out,
   output logic             q1_out,
   output logic             q2_out
);
   localparam int TAB     = 1 << LUT_K;
   localparam int H_K     = 3;
   localparam int H_TAB   = 1 << H_K;
   localparam int F_LO    = 0;
   localparam int G_LO    = F_LO + TAB;
   localparam int H_LO    = G_LO + TAB;
   localparam int FF1_LO  = H_LO + H_TAB;
   localparam int FF2_LO  = FF1_LO + FF_CFG_W;
   localparam int CFG_LEN = FF2_LO + FF_CFG_W;

   if (LUT_K < 2 || LUT_K > 6) begin : g_k_chk
      $error("lut_clb: LUT_K must lie in 2..6");
   end

   logic [CFG_LEN-1:0] image;
   logic               f_raw, g_raw, h_raw;
   ff_cfg_t            ff_cfg [2];
   logic [1:0]         q;

   clb_cfg_chain #(.LEN(CFG_LEN)) chain_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_i  (cfg_en),
      .bit_i    (cfg_bit),
      .image_o  (image),
      .loaded_o (loaded)
   );

   clb_lut #(.K(LUT_K), .MUX_TREE(MUX_TREE)) f_lut_i (
      .table_i (image[F_LO +: TAB]),
      .addr_i  (f_in),
      .out_o   (f_raw)
   );

   clb_lut #(.K(LUT_K), .MUX_TREE(MUX_TREE)) g_lut_i (
      .table_i (image[G_LO +: TAB]),
      .addr_i  (g_in),
      .out_o   (g_raw)
   );

   clb_lut #(.K(H_K), .MUX_TREE(MUX_TREE)) h_lut_i (
      .table_i (image[H_LO +: H_TAB]),
      .addr_i  ({h_in, g_raw, f_raw}),
      .out_o   (h_raw)
   );

   for (genvar n = 0; n < 2; n++) begin : g_ff
      assign ff_cfg[n] = ff_cfg_t'(image[FF1_LO + n*FF_CFG_W +: FF_CFG_W]);
      clb_ff ff_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .loaded_i (loaded),
         .src_i    (ff_cfg[n].src),
         .srval_i  (ff_cfg[n].srval),
         .f_i      (f_raw),
         .g_i      (g_raw),
         .h_i      (h_raw),
         .d_i      (d_in),
         .ce_i     (ce_in),
         .sr_i     (sr_in),
         .q_o      (q[n])
      );
   end

   assign f_out  = loaded & f_raw;
   assign g_out  = loaded & g_raw;
   assign h_out  = loaded & h_raw;
   assign q1_out = q[0];
   assign q2_out = q[1];

   // R2: no table result escapes before a full image is present
   p_comb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded |-> ({f_out, g_out, h_out} == 3'b000));

   // R2: a shift while loaded takes the block out of the loaded state
   p_reload_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded && cfg_en) |=> !loaded);

endmodule

// File: tb/lut_clb_tb_top.sv
`timescale 1ns/1ps
module lut_clb_tb_top;
   localparam int LEN = 46;

   logic clk = 1'b0;
   logic rst_n, cfg_en, cfg_bit, loaded;
   logic [3:0] f_in, g_in;
   logic h_in, d_in, ce_in, sr_in;
   logic f_out, g_out, h_out, q1_out, q2_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   lut_clb dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
      .loaded(loaded), .f_in(f_in), .g_in(g_in), .h_in(h_in),
      .d_in(d_in), .ce_in(ce_in), .sr_in(sr_in),
      .f_out(f_out), .g_out(g_out), .h_out(h_out),
      .q1_out(q1_out), .q2_out(q2_out)
   );

   // {f_in[3:0], g_in[3:0], h_in, exp_f, exp_g, exp_h}
   // F = 16'hA5C3, G = 16'h0FF0, merge = 8'hB4
   localparam logic [11:0] VEC [8] = '{
      12'h004, 12'h24A, 12'h243, 12'hDB6,
      12'h339, 12'hF3D, 12'h99A, 12'hDBF
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic shift_bits(input logic [LEN-1:0] img, input int hi, input int lo);
      for (int i = hi; i >= lo; i--) begin
         @(negedge clk);
         cfg_en  = 1'b1;
         cfg_bit = img[i];
      end
      @(negedge clk);
      cfg_en = 1'b0;
   endtask

   function automatic logic [LEN-1:0] mk_img(input logic [15:0] ft, input logic [15:0] gt,
                                             input logic [7:0] ht, input logic [1:0] s1,
                                             input logic v1, input logic [1:0] s2,
                                             input logic v2);
      return {v2, s2, v1, s1, ht, gt, ft};
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [LEN-1:0] img_a, img_b;
      logic [15:0] rf, rg;
      logic [7:0]  rh;
      logic ef, eg, eh;
      rst_n = 1'b0; cfg_en = 1'b0; cfg_bit = 1'b0;
      f_in = '0; g_in = '0; h_in = 1'b0; d_in = 1'b0; ce_in = 1'b0; sr_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 loaded after reset", loaded, 0);
      chk("R2 outputs after reset", {f_out, g_out, h_out, q1_out, q2_out}, 0);

      // ff1: merge source, set/reset value 1; ff2: direct source, value 0
      img_a = mk_img(16'hA5C3, 16'h0FF0, 8'hB4, 2'd2, 1'b1, 2'd3, 1'b0);
      shift_bits(img_a, LEN-1, 1);
      chk("R1 loaded before last bit", loaded, 0);
      shift_bits(img_a, 0, 0);
      chk("R1 loaded after 46 bits", loaded, 1);

      foreach (VEC[k]) begin
         @(negedge clk);
         f_in = VEC[k][11:8]; g_in = VEC[k][7:4]; h_in = VEC[k][3];
         #1;
         chk("R3 f_out vector", f_out, VEC[k][2]);
         chk("R3 g_out vector", g_out, VEC[k][1]);
         chk("R4 h_out vector", h_out, VEC[k][0]);
      end

      // R5 capture: merge index 7 -> 1, direct 0
      @(negedge clk);
      f_in = 4'd13; g_in = 4'd11; h_in = 1'b1; d_in = 1'b0; ce_in = 1'b1;
      @(negedge clk);
      chk("R5 q1 merge source", q1_out, 1);
      chk("R5 q2 direct source", q2_out, 0);
      f_in = 4'd3; g_in = 4'd3; h_in = 1'b0; d_in = 1'b1;
      @(negedge clk);
      chk("R5 q1 merge source 0", q1_out, 0);
      chk("R5 q2 direct source 1", q2_out, 1);

      // R7 hold with enable low
      ce_in = 1'b0; f_in = 4'd13; g_in = 4'd11; h_in = 1'b1; d_in = 1'b0;
      @(negedge clk);
      chk("R7 q1 hold", q1_out, 0);
      chk("R7 q2 hold", q2_out, 1);

      // R6 set/reset beats enable
      sr_in = 1'b1; ce_in = 1'b1;
      @(negedge clk);
      chk("R6 q1 set value", q1_out, 1);
      chk("R6 q2 reset value", q2_out, 0);
      sr_in = 1'b0;

      // R2 reload: outputs forced low part way through
      rf = 16'($urandom); rg = 16'($urandom); rh = 8'($urandom);
      img_b = mk_img(rf, rg, rh, 2'd0, 1'b0, 2'd1, 1'b1);
      f_in = 4'd0; g_in = 4'd4; h_in = 1'b0; ce_in = 1'b0;
      shift_bits(img_b, LEN-1, LEN-10);
      chk("R2 loaded low during reload", loaded, 0);
      chk("R2 comb outputs low during reload", {f_out, g_out, h_out}, 0);
      chk("R2 flops cleared during reload", {q1_out, q2_out}, 0);
      shift_bits(img_b, LEN-11, 0);
      chk("R1 loaded after reload", loaded, 1);

      ce_in = 1'b1;
      for (int n = 0; n < 24; n++) begin
         @(negedge clk);
         f_in = 4'($urandom); g_in = 4'($urandom); h_in = 1'($urandom);
         ef = rf[f_in]; eg = rg[g_in]; eh = rh[{h_in, eg, ef}];
         #1;
         chk("R3 f_out random", f_out, ef);
         chk("R3 g_out random", g_out, eg);
         chk("R4 h_out random", h_out, eh);
         @(negedge clk);
         chk("R5 q1 F source", q1_out, ef);
         chk("R5 q2 G source", q2_out, eg);
      end

      // R8 reset in operation
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R8 loaded cleared", loaded, 0);
      chk("R8 flops cleared", {q1_out, q2_out}, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule